// File: doc/BRIEF.md
# Low-Speed Serial Packet Transmitter

This block sends one reply packet on a low-speed differential serial bus made of a D+ and a D- line. A controller supplies a start strobe and a byte count. It can also ask for a handshake-only reply, which is always one byte long. The block then takes over the bus. It first drives the idle (J) level, then enables its drivers. It sends a fixed synchronisation byte followed by the caller's bytes, each least significant bit first, with NRZI encoding and bit stuffing. It ends with the end-of-packet sequence and releases the drivers.

Payload bytes are pulled from a byte source through a request/acknowledge pair. Each byte is fetched while the previous one is still on the wire, so the source has one byte time to answer. Bit timing comes from an internal divider that turns the system clock into the 1.5 Mb/s bit period. CRC generation and the choice of packet content belong to the caller.

Top module: `ls_serial_tx`

## Requirements
- R1: After reset, `oe_o`, `busy_o`, `done_o`, `byte_req_o`, `dp_o` and `dm_o` are all 0.
- R2: A start accepted at a clock edge is followed by exactly one clock of the J level (`dp_o`=0, `dm_o`=1) with `oe_o`=0. `oe_o` rises at the next edge.
- R3: The first eight bit periods carry the byte 0x80, least significant bit first, NRZI-encoded starting from J. The line sequence is K J K J K J K K.
- R4: NRZI coding: a 0 bit inverts the line level (J=`dp_o`0/`dm_o`1, K=`dp_o`1/`dm_o`0) and a 1 bit keeps it. Every bit period lasts round(CLK_HZ/BIT_HZ) clocks, which is 33 at the defaults.
- R5: After six consecutive 1 bits on the wire, one extra inverting bit is inserted before the next data bit. The run counts across byte boundaries, and the extra bit is also inserted when the run ends the last byte.
- R6: Caller bytes are sent in the order they are fetched. `byte_req_o` rises after the start and stays high until `byte_ack_i`. `byte_i` is taken at the edge where both are high. Exactly as many bytes are requested as are sent.
- R7: After the last bit, both lines are low for two bit periods, then J is driven for one bit period, then `oe_o` falls.
- R8: With `hs_only_i`=1 exactly one caller byte is sent, whatever `len_i` holds. Otherwise `len_i` bytes are sent, and `len_i`=0 sends the sync byte alone.
- R9: `busy_o` is high from the clock after the accepted start until `oe_o` falls. `done_o` is a single-clock pulse in the first clock with `oe_o` and `busy_o` low.
- R10: `start_i`, `len_i` and `hs_only_i` have no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send one packet |
| hs_only_i | input | 1 | Send a one-byte handshake reply |
| len_i | input | LEN_W | Number of caller bytes for a data reply |
| byte_req_o | output | 1 | Next payload byte wanted |
| byte_ack_i | input | 1 | Byte source presents `byte_i` |
| byte_i | input | 8 | Payload byte |
| dp_o | output | 1 | D+ level |
| dm_o | output | 1 | D- level |
| oe_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | Drivers released (one clock) |

## Verification
Two events can fall on the same bit boundary. One is a stuffed bit that becomes due. The other is the loading of the next byte, or the end of data that hands over to the end-of-packet sequence. Both are provoked with payloads of all-ones bytes and a final byte whose top six bits are ones. Random payloads are mixed in. The bench rebuilds the expected J/K/SE0 symbol per bit period from the requirements and compares it at the centre of each period. It also checks that the driver release and the fetch count land where expected.

// File: rtl/ls_tx_pkg.sv
package ls_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_BITS = 2'd2,
    ST_EOP  = 2'd3
  } tx_state_t;

  localparam logic [7:0] SYNC_BYTE  = 8'h80;
  localparam int         STUFF_RUN  = 6;
  localparam int         SE0_BITS   = 2;

endpackage

// File: rtl/ls_tx_bit_timer.sv
module ls_tx_bit_timer #(
  parameter int DIV = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = run_i && (cnt_q == LAST);
    cnt_d  = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: bit periods are longer than one clock
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  a_r4_tick_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !tick_o);

endmodule

// File: rtl/ls_tx_fetch.sv
module ls_tx_fetch #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             take_i,
  input  logic             byte_ack_i,
  input  logic [7:0]       byte_i,
  output logic             byte_req_o,
  output logic             more_o,
  output logic [7:0]       nxt_byte_o
);

  logic [LEN_W-1:0] left_q, left_d;
  logic             req_q, req_d;
  logic [7:0]       hold_q, hold_d;
  logic             cap;

  always_comb begin
    left_d = left_q;
    req_d  = req_q;
    hold_d = hold_q;
    cap    = req_q && byte_ack_i;
    if (cap) hold_d = byte_i;
    if (start_i) begin
      left_d = len_i;
      req_d  = (len_i != '0);
    end else if (take_i) begin
      left_d = left_q - 1'b1;
      req_d  = (left_q != LEN_W'(1));
    end else if (cap) begin
      req_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      req_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      left_q <= left_d;
      req_q  <= req_d;
      hold_q <= hold_d;
    end
  end

  assign byte_req_o = req_q;
  assign more_o     = (left_q != '0);
  assign nxt_byte_o = hold_q;

  // R6: request is held until acknowledged
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req_o && !byte_ack_i |=> byte_req_o);
  // R6: no byte is taken when none remains
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> more_o);

endmodule

// File: rtl/ls_tx_nrzi.sv
module ls_tx_nrzi
  import ls_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       adv_i,
  input  logic       more_i,
  input  logic [7:0] nxt_byte_i,
  output logic       line_j_o,
  output logic       take_o,
  output logic       end_o
);

  logic [7:0] sh_q, sh_d;
  logic [3:0] left_q, left_d;
  logic [2:0] ones_q, ones_d;
  logic       line_q, line_d;
  logic       stuff;

  always_comb begin
    stuff  = (ones_q == 3'(STUFF_RUN));
    end_o  = !stuff && (left_q == 4'd0);
    take_o = adv_i && !stuff && (left_q == 4'd1) && more_i;
    sh_d   = sh_q;
    left_d = left_q;
    ones_d = ones_q;
    line_d = line_q;
    if (load_i) begin
      sh_d   = SYNC_BYTE;
      left_d = 4'd8;
      ones_d = '0;
      line_d = 1'b1;
    end else if (adv_i && !end_o) begin
      if (stuff) begin
        line_d = !line_q;
        ones_d = '0;
      end else begin
        if (sh_q[0]) begin
          ones_d = ones_q + 1'b1;
        end else begin
          ones_d = '0;
          line_d = !line_q;
        end
        if (left_q == 4'd1) begin
          if (more_i) begin
            sh_d   = nxt_byte_i;
            left_d = 4'd8;
          end else begin
            left_d = 4'd0;
          end
        end else begin
          sh_d   = {1'b0, sh_q[7:1]};
          left_d = left_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      ones_q <= '0;
      line_q <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      ones_q <= ones_d;
      line_q <= line_d;
    end
  end

  assign line_j_o = line_q;

  // R5: the wire never carries more than six equal-level-keeping bits
  a_r5_run_cap: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= 3'(STUFF_RUN));
  // R5: a due stuff bit always inverts the line
  a_r5_stuff_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && stuff && !load_i |=> line_j_o != $past(line_j_o));

endmodule

// File: rtl/ls_serial_tx.sv
module ls_serial_tx
  import ls_tx_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int BIT_HZ  = 1_500_000,
  parameter int MAX_LEN = 64,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             hs_only_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             byte_req_o,
  input  logic             byte_ack_i,
  input  logic [7:0]       byte_i,
  output logic             dp_o,
  output logic             dm_o,
  output logic             oe_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int DIV = (CLK_HZ + BIT_HZ / 2) / BIT_HZ;

  tx_state_t        st_q, st_d;
  logic [1:0]       eop_q, eop_d;
  logic             done_q, done_d;
  logic             start_ok, adv, tick, run;
  logic             line_j, take, more, data_end;
  logic [7:0]       nxt_byte;
  logic [LEN_W-1:0] eff_len;

  assign start_ok = (st_q == ST_IDLE) && start_i;
  assign eff_len  = hs_only_i ? LEN_W'(1) : len_i;
  assign run      = (st_q == ST_BITS) || (st_q == ST_EOP);
  assign adv      = (st_q == ST_ARM) || ((st_q == ST_BITS) && tick);

  ls_tx_bit_timer #(.DIV(DIV)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .tick_o (tick)
  );

  ls_tx_fetch #(.LEN_W(LEN_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_ok),
    .len_i      (eff_len),
    .take_i     (take),
    .byte_ack_i (byte_ack_i),
    .byte_i     (byte_i),
    .byte_req_o (byte_req_o),
    .more_o     (more),
    .nxt_byte_o (nxt_byte)
  );

  ls_tx_nrzi u_nrzi (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_ok),
    .adv_i      (adv),
    .more_i     (more),
    .nxt_byte_i (nxt_byte),
    .line_j_o   (line_j),
    .take_o     (take),
    .end_o      (data_end)
  );

  always_comb begin
    st_d   = st_q;
    eop_d  = eop_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_ARM;
      ST_ARM:  st_d = ST_BITS;
      ST_BITS: if (tick && data_end) begin
        st_d  = ST_EOP;
        eop_d = '0;
      end
      ST_EOP: if (tick) begin
        if (eop_q == 2'(SE0_BITS)) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          eop_d = eop_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      eop_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      eop_q  <= eop_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    oe_o = run;
    dp_o = 1'b0;
    dm_o = 1'b0;
    unique case (st_q)
      ST_ARM:  dm_o = 1'b1;
      ST_BITS: begin
        dp_o = !line_j;
        dm_o = line_j;
      end
      ST_EOP:  dm_o = (eop_q == 2'(SE0_BITS));
      default: ;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;

  // R2: drivers turn on only after a clock of undriven J
  a_r2_j_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> $past(dm_o && !dp_o && !oe_o && busy_o));
  // R7: the last driven level before release is J
  a_r7_release_after_j: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_o) |-> $past(dm_o && !dp_o));
  // R9: drivers enabled only while busy, done is a lone pulse at release
  a_r9_oe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> busy_o);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !oe_o && $past(oe_o));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10: a packet in progress is never restarted
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> st_q != ST_ARM);

endmodule

// File: tb/tb_ls_serial_tx.sv
module tb_ls_serial_tx;

  localparam int LEN_W = 7;
  localparam int DIV   = (50_000_000 + 750_000) / 1_500_000;
  localparam int SYM_J = 0, SYM_K = 1, SYM_SE0 = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, hs_only_i, byte_ack_i;
  logic [LEN_W-1:0] len_i;
  logic [7:0] byte_i;
  logic byte_req_o, dp_o, dm_o, oe_o, busy_o, done_o;

  int n_chk = 0, n_bad = 0;
  int done_cnt = 0;
  int src_idx = 0;
  int nsym;
  logic [7:0] pay [0:15];
  int exp_sym [0:255];

  always #10 clk = ~clk;

  ls_serial_tx dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hs_only_i(hs_only_i),
    .len_i(len_i), .byte_req_o(byte_req_o), .byte_ack_i(byte_ack_i),
    .byte_i(byte_i), .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int sym_now();
    if (!dp_o && dm_o) return SYM_J;
    if (dp_o && !dm_o) return SYM_K;
    if (!dp_o && !dm_o) return SYM_SE0;
    return 3;
  endfunction

  // expected wire symbols from the requirements (R3 R4 R5 R7)
  function automatic void build_exp(input int nbytes);
    int ones = 0;
    int line = SYM_J;
    nsym = 0;
    for (int b = 0; b <= nbytes; b++) begin
      logic [7:0] v = (b == 0) ? 8'h80 : pay[b-1];
      for (int i = 0; i < 8; i++) begin
        if (ones == 6) begin
          line = 1 - line; exp_sym[nsym++] = line; ones = 0;
        end
        if (!v[i]) begin line = 1 - line; ones = 0; end
        else ones++;
        exp_sym[nsym++] = line;
      end
    end
    if (ones == 6) begin line = 1 - line; exp_sym[nsym++] = line; end
    exp_sym[nsym++] = SYM_SE0;
    exp_sym[nsym++] = SYM_SE0;
    exp_sym[nsym++] = SYM_J;
  endfunction

  // byte source: acknowledges after a random 0..2 clock delay
  initial begin
    int wait_cnt = 0;
    byte_ack_i = 1'b0;
    byte_i = 8'h00;
    forever begin
      @(negedge clk);
      byte_ack_i = 1'b0;
      if (byte_req_o) begin
        if (wait_cnt == 0) begin
          byte_ack_i = 1'b1;
          byte_i = pay[src_idx % 16];
          src_idx++;
          wait_cnt = $urandom % 3;
        end else wait_cnt--;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done_o) done_cnt++;
    end
  end

  task automatic run_pkt(input int n, input bit hs, input bit poke);
    int eff = hs ? 1 : n;
    int d0;
    build_exp(eff);
    src_idx = 0;
    d0 = done_cnt;
    @(negedge clk);
    len_i = LEN_W'(n); hs_only_i = hs; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 oe low in arm", oe_o, 0);
    check("R2 J in arm", sym_now(), SYM_J);
    check("R9 busy after start", busy_o, 1);
    @(negedge clk);
    check("R2 oe rises", oe_o, 1);
    repeat (DIV / 2) @(negedge clk);
    for (int i = 0; i < nsym; i++) begin
      check(i < 8 ? "R3 sync symbol" : "R4/R5/R7 symbol", sym_now(), exp_sym[i]);
      if (poke && i == 3) begin
        start_i = 1'b1; len_i = LEN_W'(9); hs_only_i = 1'b0;
      end
      if (poke && i == 4) start_i = 1'b0;
      repeat (DIV) @(negedge clk);
    end
    check("R7 oe released", oe_o, 0);
    check("R9 busy released", busy_o, 0);
    check("R9 one done pulse", done_cnt - d0, 1);
    check("R6/R8 bytes fetched", src_idx, eff);
    if (poke) begin
      repeat (3 * DIV) @(negedge clk);
      check("R10 no restart", busy_o, 0);
      check("R10 no drive", oe_o, 0);
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start_i = 1'b0; hs_only_i = 1'b0; len_i = '0;
    for (int i = 0; i < 16; i++) pay[i] = 8'h00;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 oe", oe_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 req", byte_req_o, 0);
    check("R1 dp", dp_o, 0);
    check("R1 dm", dm_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: all-ones bytes, stuffing across boundaries and at the end
    for (int i = 0; i < 3; i++) pay[i] = 8'hFF;
    run_pkt(3, 1'b0, 1'b0);
    // R5: last byte ends with six ones
    pay[0] = 8'h5A; pay[1] = 8'hFC;
    run_pkt(2, 1'b0, 1'b0);
    // R8: handshake mode ignores len_i
    pay[0] = 8'hD2;
    run_pkt(5, 1'b1, 1'b0);
    // R8: zero length sends sync only
    run_pkt(0, 1'b0, 1'b0);
    // R10: start pulsed mid-packet is ignored
    pay[0] = 8'h00; pay[1] = 8'h7E;
    run_pkt(2, 1'b0, 1'b1);
    // R4 R6: random payloads
    for (int k = 0; k < 10; k++) begin
      int n = $urandom_range(1, 12);
      for (int i = 0; i < 16; i++)
        pay[i] = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
      run_pkt(n, ($urandom % 4) == 0, ($urandom % 3) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule